// File: doc/BRIEF.md
# Half-Precision Round-to-Integral Unit

This block rounds an IEEE 754 binary16 operand to an integral value and returns that value in binary16. Seven operation codes share one rounding datapath. Five of them force a rounding mode: ties-to-even, toward minus infinity, toward plus infinity, toward zero, or ties-away-from-zero. The other two take the rounding mode from a dynamic mode input. Only one of the seven codes reports the inexact condition. The rest silence it.

A small front end splits the 7-bit selector into a rounding mode and an exact or non-exact choice. It also rejects any selector that is not allocated, and any request marked as scalar, because these operations exist only in vector form. The datapath handles NaNs, infinities, signed zeros, subnormals and operands that are already integral. One output register stage, enabled by default, aligns the result and its flags with a valid strobe.

Top module: `hp_rint_unit`

## Requirements
- R1: The selector is built as bits 4..0 = opcode, bit 5 = `a`, bit 6 = `u`. The forced modes are: 0x18 rounds to nearest with ties to even, 0x19 rounds toward minus infinity, 0x38 rounds toward plus infinity, 0x39 rounds toward zero, and 0x58 rounds to nearest with ties away from zero.
- R2: Selectors 0x59 and 0x79 use `in_dyn_mode`, encoded as 2'b00 nearest-even, 2'b01 toward plus infinity, 2'b10 toward minus infinity, and 2'b11 toward zero.
- R3: `out_inexact` is set only for selector 0x59, and only when a finite non-NaN result differs from the operand. Every other selector leaves it at 0.
- R4: A request with `in_scalar` = 1 sets `out_unalloc`, returns result 0x0000, and sets neither flag, whatever the operand.
- R5: Any selector outside the seven listed sets `out_unalloc`, returns 0x0000, and sets no flags.
- R6: An operand with biased exponent of 25 or more (unbiased exponent of 10 or more) is returned unchanged with no flags. This includes the infinities 0x7C00 and 0xFC00.
- R7: The sign of the result always equals the sign of the operand. A negative operand that rounds to zero returns 0x8000, and -0.0 returns 0x8000.
- R8: A signalling NaN (exponent all ones, fraction nonzero, fraction bit 9 = 0) sets `out_invalid` and returns the operand with bit 9 set. A quiet NaN is returned unchanged with no flags.
- R9: A nonzero magnitude below 1.0, subnormals included, returns ±0x0000 or ±0x3C00 (sign in bit 15) according to the selected mode. An exact 0.5 counts as a tie.
- R10: `out_valid` and all result fields appear on the clock edge after the edge that samples `in_valid`. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 16 | binary16 operand |
| in_sel | input | 7 | Operation selector {u, a, opcode} |
| in_scalar | input | 1 | Scalar-form request flag |
| in_dyn_mode | input | 2 | Dynamic rounding mode |
| out_valid | output | 1 | Result strobe |
| out_result | output | 16 | Rounded binary16 result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_unalloc | output | 1 | Unallocated-operation indication |

## Verification
Each request produces its result, flags and strobe exactly one clock after the edge that accepts it, since one register stage sits between inputs and outputs. The bench drives requests back to back on falling edges and records the expected record in a queue at that moment. A monitor compares on the next falling edge, so every comparison lands one full cycle after its request. Any strobe that arrives with an empty queue, or any entry still pending at the end, is reported as a timing failure.

// File: rtl/hp_rint_pkg.sv
package hp_rint_pkg;

   typedef enum logic [2:0] {
      RND_TIE_EVEN = 3'd0,
      RND_UP       = 3'd1,
      RND_DOWN     = 3'd2,
      RND_TRUNC    = 3'd3,
      RND_TIE_AWAY = 3'd4
   } rnd_mode_e;

   localparam logic [6:0] SEL_NEAREST = 7'h18;
   localparam logic [6:0] SEL_FLOOR   = 7'h19;
   localparam logic [6:0] SEL_CEIL    = 7'h38;
   localparam logic [6:0] SEL_TRUNC   = 7'h39;
   localparam logic [6:0] SEL_AWAY    = 7'h58;
   localparam logic [6:0] SEL_DYN_EX  = 7'h59;
   localparam logic [6:0] SEL_DYN     = 7'h79;

   function automatic rnd_mode_e dyn_to_mode(input logic [1:0] code);
      case (code)
         2'b00:   return RND_TIE_EVEN;
         2'b01:   return RND_UP;
         2'b10:   return RND_DOWN;
         default: return RND_TRUNC;
      endcase
   endfunction

   // Increment decision for a magnitude with discarded bits.
   function automatic logic want_increment(input rnd_mode_e m, input logic neg,
                                           input logic lost, input logic above,
                                           input logic tie, input logic lsb);
      case (m)
         RND_TIE_EVEN: return above | (tie & lsb);
         RND_TIE_AWAY: return above | tie;
         RND_UP:       return lost & ~neg;
         RND_DOWN:     return lost & neg;
         default:      return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/hp_rint_decode.sv
module hp_rint_decode
   import hp_rint_pkg::*;
#(
   parameter int SEL_W = 7
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             scalar,
   input  logic [1:0]       dyn_mode,
   output rnd_mode_e        mode,
   output logic             exact,
   output logic             unalloc
);

   if (SEL_W != 7) begin : g_bad_sel_w
      $error("hp_rint_decode: SEL_W must be 7");
   end

   logic allocated;

   always_comb begin
      mode      = RND_TIE_EVEN;
      exact     = 1'b0;
      allocated = 1'b1;
      case (sel)
         SEL_NEAREST: mode = RND_TIE_EVEN;
         SEL_FLOOR:   mode = RND_DOWN;
         SEL_CEIL:    mode = RND_UP;
         SEL_TRUNC:   mode = RND_TRUNC;
         SEL_AWAY:    mode = RND_TIE_AWAY;
         SEL_DYN_EX: begin
            mode  = dyn_to_mode(dyn_mode);
            exact = 1'b1;
         end
         SEL_DYN:     mode = dyn_to_mode(dyn_mode);
         default:     allocated = 1'b0;
      endcase
      unalloc = ~allocated | scalar;
   end

endmodule

// File: rtl/hp_rint_core.sv
module hp_rint_core
   import hp_rint_pkg::*;
#(
   parameter int EXP_W = 5,
   parameter int MAN_W = 10
) (
   input  logic [EXP_W+MAN_W:0] op,
   input  rnd_mode_e            mode,
   output logic [EXP_W+MAN_W:0] res,
   output logic                 invalid,
   output logic                 lost
);

   localparam int W       = EXP_W + MAN_W + 1;
   localparam int MAG_W   = W - 1;
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int INT_EXP = BIAS + MAN_W;
   localparam logic [MAG_W-1:0] ONE_MAG = MAG_W'(BIAS) << MAN_W;
   localparam logic [MAG_W-1:0] QUIET   = MAG_W'(1) << (MAN_W - 1);

   if (EXP_W < 3 || MAN_W < 2) begin : g_bad_fmt
      $error("hp_rint_core: format too narrow");
   end

   logic             sgn;
   logic [EXP_W-1:0] ex;
   logic [MAN_W-1:0] fr;
   logic [MAG_W-1:0] mag;
   logic [MAG_W-1:0] low_mask;
   logic [MAG_W-1:0] rem;
   logic [MAG_W-1:0] half;
   logic [MAG_W-1:0] step;
   logic             inc;
   int               fb;

   assign sgn = op[W-1];
   assign ex  = op[W-2:MAN_W];
   assign fr  = op[MAN_W-1:0];
   assign mag = op[MAG_W-1:0];

   always_comb begin
      res      = op;
      invalid  = 1'b0;
      lost     = 1'b0;
      inc      = 1'b0;
      fb       = 1;
      low_mask = '0;
      rem      = '0;
      half     = '0;
      step     = '0;
      if (&ex) begin
         if (fr != '0) begin
            invalid = ~fr[MAN_W-1];
            res     = {sgn, mag | QUIET};
         end
      end else if (int'(ex) >= INT_EXP) begin
         res = op;
      end else if (int'(ex) < BIAS) begin
         if (mag != '0) begin
            lost = 1'b1;
            inc  = want_increment(mode, sgn, 1'b1,
                                  (int'(ex) == BIAS - 1) && (fr != '0),
                                  (int'(ex) == BIAS - 1) && (fr == '0),
                                  1'b0);
            res  = {sgn, inc ? ONE_MAG : '0};
         end
      end else begin
         fb       = INT_EXP - int'(ex);
         low_mask = ~({MAG_W{1'b1}} << fb);
         rem      = mag & low_mask;
         half     = MAG_W'(1) << (fb - 1);
         step     = MAG_W'(1) << fb;
         lost     = rem != '0;
         inc      = want_increment(mode, sgn, lost, rem > half, rem == half,
                                   |(mag & step));
         res      = {sgn, (mag & ~low_mask) + (inc ? step : '0)};
      end
   end

endmodule

// File: rtl/hp_rint_unit.sv
module hp_rint_unit
   import hp_rint_pkg::*;
#(
   parameter int EXP_W   = 5,
   parameter int MAN_W   = 10,
   parameter int SEL_W   = 7,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [EXP_W+MAN_W:0] in_operand,
   input  logic [SEL_W-1:0]     in_sel,
   input  logic                 in_scalar,
   input  logic [1:0]           in_dyn_mode,
   output logic                 out_valid,
   output logic [EXP_W+MAN_W:0] out_result,
   output logic                 out_invalid,
   output logic                 out_inexact,
   output logic                 out_unalloc
);

   localparam int W = EXP_W + MAN_W + 1;

   rnd_mode_e      mode;
   logic           exact;
   logic           unalloc;
   logic [W-1:0]   core_res;
   logic           core_inv;
   logic           core_lost;
   logic [W-1:0]   nxt_res;
   logic           nxt_inv;
   logic           nxt_inx;

   hp_rint_decode #(.SEL_W(SEL_W)) dec_i (
      .sel      (in_sel),
      .scalar   (in_scalar),
      .dyn_mode (in_dyn_mode),
      .mode     (mode),
      .exact    (exact),
      .unalloc  (unalloc)
   );

   hp_rint_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) core_i (
      .op      (in_operand),
      .mode    (mode),
      .res     (core_res),
      .invalid (core_inv),
      .lost    (core_lost)
   );

   assign nxt_res = unalloc ? '0 : core_res;
   assign nxt_inv = ~unalloc & core_inv;
   assign nxt_inx = ~unalloc & exact & core_lost;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
            out_unalloc <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_result  <= nxt_res;
               out_invalid <= nxt_inv;
               out_inexact <= nxt_inx;
               out_unalloc <= unalloc;
            end
         end
      end
   end else begin : g_comb
      assign out_valid   = in_valid;
      assign out_result  = nxt_res;
      assign out_invalid = nxt_inv;
      assign out_inexact = nxt_inx;
      assign out_unalloc = unalloc;
   end

endmodule

// File: rtl/hp_rint_chk.sv
module hp_rint_chk #(
   parameter int EXP_W   = 5,
   parameter int MAN_W   = 10,
   parameter int SEL_W   = 7,
   parameter bit OUT_REG = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [EXP_W+MAN_W:0] in_operand,
   input logic [SEL_W-1:0]     in_sel,
   input logic                 in_scalar,
   input logic                 out_valid,
   input logic [EXP_W+MAN_W:0] out_result,
   input logic                 out_invalid,
   input logic                 out_inexact,
   input logic                 out_unalloc
);

   localparam int W = EXP_W + MAN_W + 1;

   if (OUT_REG) begin : g_reg_chk
      // R10
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R10
      valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      // R3
      inexact_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_inexact) |-> ($past(in_sel) == SEL_W'(7'h59) && !$past(in_scalar)));
      // R4
      scalar_unalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_scalar) |=> out_unalloc);
      // R7
      sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_unalloc) |-> (out_result[W-1] == $past(in_operand[W-1])));
   end

   // R5
   unalloc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_unalloc) |-> (!out_invalid && !out_inexact && out_result == '0));
   // R8
   invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> ((&out_result[W-2:MAN_W]) && out_result[MAN_W-1]));

endmodule

bind hp_rint_unit hp_rint_chk #(
   .EXP_W(EXP_W), .MAN_W(MAN_W), .SEL_W(SEL_W), .OUT_REG(OUT_REG)
) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
   .in_sel(in_sel), .in_scalar(in_scalar), .out_valid(out_valid),
   .out_result(out_result), .out_invalid(out_invalid),
   .out_inexact(out_inexact), .out_unalloc(out_unalloc)
);

// File: tb/hp_rint_unit_tb_top.sv
`timescale 1ns/1ps
module hp_rint_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_operand = '0;
   logic [6:0]  in_sel = '0;
   logic        in_scalar = 1'b0;
   logic [1:0]  in_dyn_mode = '0;
   logic        out_valid;
   logic [15:0] out_result;
   logic        out_invalid;
   logic        out_inexact;
   logic        out_unalloc;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [15:0] q_res[$];
   logic [2:0]  q_flg[$];
   string       q_tag[$];

   always #4 clk = ~clk;

   hp_rint_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
      .in_sel(in_sel), .in_scalar(in_scalar), .in_dyn_mode(in_dyn_mode),
      .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
      .out_inexact(out_inexact), .out_unalloc(out_unalloc)
   );

   // flags packed as {invalid, inexact, unalloc}
   task automatic send(input logic [15:0] op, input logic [6:0] sel,
                       input logic sc, input logic [1:0] dm,
                       input logic [15:0] er, input logic [2:0] ef,
                       input string tag);
      @(negedge clk);
      in_valid    = 1'b1;
      in_operand  = op;
      in_sel      = sel;
      in_scalar   = sc;
      in_dyn_mode = dm;
      q_res.push_back(er);
      q_flg.push_back(ef);
      q_tag.push_back(tag);
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (q_res.size() == 0) begin
            failures++;
            $display("FAIL R10 unexpected out_valid: actual=1 expected=0");
         end else begin
            logic [15:0] er;
            logic [2:0]  ef;
            string       tg;
            er = q_res.pop_front();
            ef = q_flg.pop_front();
            tg = q_tag.pop_front();
            if (out_result !== er || {out_invalid, out_inexact, out_unalloc} !== ef) begin
               failures++;
               $display("FAIL %s: actual res=%h flags=%b expected res=%h flags=%b",
                        tg, out_result, {out_invalid, out_inexact, out_unalloc}, er, ef);
            end
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_result !== 16'h0 || out_invalid !== 1'b0 ||
          out_inexact !== 1'b0 || out_unalloc !== 1'b0) begin
         failures++;
         $display("FAIL R10 reset: actual v=%b res=%h expected v=0 res=0000",
                  out_valid, out_result);
      end

      // R1 forced modes on 2.5 / -2.5 / 3.5 / 1023.5
      send(16'h4100, 7'h18, 0, 2'b00, 16'h4000, 3'b000, "R1 tie-even 2.5");
      send(16'h4300, 7'h18, 0, 2'b00, 16'h4400, 3'b000, "R1 tie-even 3.5");
      send(16'h63FF, 7'h18, 0, 2'b00, 16'h6400, 3'b000, "R1 tie-even 1023.5");
      send(16'hC100, 7'h19, 0, 2'b00, 16'hC200, 3'b000, "R1 floor -2.5");
      send(16'h4100, 7'h19, 0, 2'b00, 16'h4000, 3'b000, "R1 floor 2.5");
      send(16'h4100, 7'h38, 0, 2'b00, 16'h4200, 3'b000, "R1 ceil 2.5");
      send(16'hC100, 7'h38, 0, 2'b00, 16'hC000, 3'b000, "R1 ceil -2.5");
      send(16'h4100, 7'h39, 0, 2'b00, 16'h4000, 3'b000, "R1 trunc 2.5");
      send(16'hC100, 7'h58, 0, 2'b00, 16'hC200, 3'b000, "R1 away -2.5");
      // R2 dynamic modes / R3 inexact
      send(16'h4100, 7'h59, 0, 2'b00, 16'h4000, 3'b010, "R2 R3 exact dyn-even 2.5");
      send(16'h4100, 7'h79, 0, 2'b01, 16'h4200, 3'b000, "R2 R3 dyn-up 2.5 no inexact");
      send(16'h4100, 7'h59, 0, 2'b10, 16'h4000, 3'b010, "R2 exact dyn-down 2.5");
      send(16'hC100, 7'h79, 0, 2'b11, 16'hC000, 3'b000, "R2 dyn-zero -2.5");
      send(16'h4000, 7'h59, 0, 2'b01, 16'h4000, 3'b000, "R3 exact on integral 2.0");
      // R4 scalar, R5 unallocated
      send(16'h4100, 7'h18, 1, 2'b00, 16'h0000, 3'b001, "R4 scalar form");
      send(16'h7C01, 7'h59, 1, 2'b00, 16'h0000, 3'b001, "R4 scalar sNaN no flags");
      send(16'h4100, 7'h1A, 0, 2'b00, 16'h0000, 3'b001, "R5 unallocated 0x1A");
      send(16'h4100, 7'h78, 0, 2'b00, 16'h0000, 3'b001, "R5 unallocated 0x78");
      // R6 already integral, infinities
      send(16'h6400, 7'h59, 0, 2'b01, 16'h6400, 3'b000, "R6 1024.0 unchanged");
      send(16'h7C00, 7'h38, 0, 2'b00, 16'h7C00, 3'b000, "R6 +inf");
      send(16'hFC00, 7'h59, 0, 2'b00, 16'hFC00, 3'b000, "R6 -inf");
      // R7 signed zero
      send(16'hB800, 7'h18, 0, 2'b00, 16'h8000, 3'b000, "R7 -0.5 to -0");
      send(16'hB400, 7'h38, 0, 2'b00, 16'h8000, 3'b000, "R7 -0.25 ceil to -0");
      send(16'h8000, 7'h59, 0, 2'b01, 16'h8000, 3'b000, "R7 -0.0 kept");
      // R8 NaNs
      send(16'h7C01, 7'h59, 0, 2'b00, 16'h7E01, 3'b100, "R8 sNaN quieted");
      send(16'hFD00, 7'h18, 0, 2'b00, 16'hFF00, 3'b100, "R8 negative sNaN");
      send(16'h7E00, 7'h59, 0, 2'b00, 16'h7E00, 3'b000, "R8 qNaN passes");
      // R9 below one
      send(16'h3800, 7'h18, 0, 2'b00, 16'h0000, 3'b000, "R9 0.5 tie-even");
      send(16'h3800, 7'h58, 0, 2'b00, 16'h3C00, 3'b000, "R9 0.5 away");
      send(16'h3A00, 7'h18, 0, 2'b00, 16'h3C00, 3'b000, "R9 0.75 nearest");
      send(16'hB400, 7'h19, 0, 2'b00, 16'hBC00, 3'b000, "R9 -0.25 floor");
      send(16'h0001, 7'h38, 0, 2'b00, 16'h3C00, 3'b000, "R9 subnormal ceil");
      send(16'h0001, 7'h59, 0, 2'b11, 16'h0000, 3'b010, "R9 subnormal exact trunc");
      @(negedge clk);
      in_valid = 1'b0;
      // R10 idle gap then a single request
      repeat (3) @(negedge clk);
      send(16'h3C00, 7'h39, 0, 2'b00, 16'h3C00, 3'b000, "R10 single after gap");
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (q_res.size() != 0) begin
         failures++;
         $display("FAIL R10 pending results: actual=%0d expected=0", q_res.size());
      end
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule